// File: doc/BRIEF.md
# Indexed Block Configuration Register Target

This block is a two-wire serial target that lets a host reach a small bank of eight-bit configuration registers by index. It recognises one write address and one read address, follows START, repeated START and STOP, and frames every transfer with a starting index. A write then carries a byte count and that many data bytes. A read, opened by a repeated START, returns the programmable byte count first and then consecutive registers.

The bank holds a control register whose upper bits latch five strap pins once after reset and accept host writes only while a software-select bit is set. It also holds two gated enable registers, a live view of the same five pins, fixed identification bytes and the read byte-count register. The serial lines are oversampled by the system clock. SDA is open-drain and is modelled as an input, an output-enable and an output that is always low.

Top module: `smb_cfg_target`

## Requirements
- R1: Only the write address 0xDC and the read address 0xDD are acknowledged. Any other address byte is not acknowledged, and the target ignores the bus until the next START.
- R2: A write frame carries the write address, a starting index N, a byte count X and then data bytes, each acknowledged. The data bytes go to N, N+1 and onward. Once X bytes have been stored, further data bytes are not acknowledged and are dropped.
- R3: A read frame carries the write address, the index N, a repeated START and the read address. The target then sends the value of register 6, followed by registers N, N+1 and onward for that many bytes. After those bytes SDA stays released, so the host reads 0xFF.
- R4: Register 6 is read/write and resets to 0x07. The byte count in a write frame does not change it.
- R5: Register 0 bits 7..4 take pin_fsel[3:0] and bit 3 takes pin_spread on the first clock after reset. Bits 2..0 reset to 0 and are always writable. Bits 7..3 accept a write only if bit 2 is already 1 before that byte is written.
- R6: In registers 1 and 2 only bits 6, 5, 2 and 1 are stored. The other bits read as 0. Register 1 resets to 0x66 and register 2 resets to 0x00. cfg_oen_o and cfg_stopen_o show these registers.
- R7: Register 3 reads {pin_fsel, pin_spread, 3'b000} from the live pins, whatever the software-select bit holds.
- R8: Register 4 reads 0x81 and register 5 reads 0x08. Indexes of 7 and above read 0x00. Writes to any of these are acknowledged and have no effect.
- R9: A STOP or START in the middle of a byte abandons the transfer without writing a partial byte. A START then begins a new address phase.
- R10: The target changes its SDA drive only after SCL falls, or on START or STOP. After a STOP it releases SDA. It only ever pulls SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_o | output | 1 | Driven value of SDA, always 0 |
| pin_fsel | input | 4 | Frequency-select strap pins |
| pin_spread | input | 1 | Spread-enable strap pin |
| cfg_ctrl_o | output | 8 | Register 0 contents |
| cfg_oen_o | output | 8 | Register 1 contents (output enables) |
| cfg_stopen_o | output | 8 | Register 2 contents (stop enables) |

## Verification
The checks that run on every cycle cover four points. SDA drive changes only after a falling SCL edge or a bus condition, and SDA is released after STOP. A write strobe to the count register lands exactly in that register. The strap-latched control bits hold still while software select is clear. Address filtering, index auto-increment, the count byte leading each read, the released 0xFF bytes past the count, the dropping of surplus write bytes and aborts in mid-byte span whole transfers. Only the bench's scripted host sequences can show these.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] IDX_CTRL   = 8'd0;
  localparam logic [7:0] IDX_OEN    = 8'd1;
  localparam logic [7:0] IDX_STOPEN = 8'd2;
  localparam logic [7:0] IDX_PINS   = 8'd3;
  localparam logic [7:0] IDX_REVVEN = 8'd4;
  localparam logic [7:0] IDX_DEVID  = 8'd5;
  localparam logic [7:0] IDX_COUNT  = 8'd6;

  localparam logic [7:0] GATE_MASK   = 8'h66;
  localparam logic [7:0] OEN_RESET   = 8'h66;
  localparam logic [7:0] COUNT_RESET = 8'h07;
  localparam logic [7:0] REVVEN_VAL  = 8'h81;
  localparam logic [7:0] DEVID_VAL   = 8'h08;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INDEX, ST_INDEX_ACK,
    ST_COUNT, ST_COUNT_ACK, ST_WDATA, ST_WDATA_ACK, ST_TX, ST_TX_ACK
  } link_state_e;

  // Control register update: strap bits only move while software select is set.
  function automatic logic [7:0] ctrl_merge(input logic [7:0] cur, input logic [7:0] wdat);
    ctrl_merge = cur[2] ? wdat : {cur[7:3], wdat[2:0]};
  endfunction

  // Acknowledge slot that follows each receive state.
  function automatic link_state_e ack_slot(input link_state_e s);
    case (s)
      ST_ADDR:  ack_slot = ST_ADDR_ACK;
      ST_INDEX: ack_slot = ST_INDEX_ACK;
      ST_COUNT: ack_slot = ST_COUNT_ACK;
      default:  ack_slot = ST_WDATA_ACK;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
  assign ev_rise  = scl_s & ~scl_d;
  assign ev_fall  = ~scl_s & scl_d;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pin_fsel,
  input  logic       pin_spread,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] ctrl_o,
  output logic [7:0] oen_o,
  output logic [7:0] stopen_o,
  output logic [7:0] count_o,
  output logic       cap_done_o
);
  logic [4:0] pins_q;
  logic       cap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= 8'h00;
      oen_o    <= OEN_RESET;
      stopen_o <= 8'h00;
      count_o  <= COUNT_RESET;
      pins_q   <= 5'd0;
      cap_done <= 1'b0;
    end else begin
      pins_q <= {pin_fsel, pin_spread};
      if (!cap_done) begin
        ctrl_o[7:3] <= {pin_fsel, pin_spread};
        cap_done    <= 1'b1;
      end else if (wr_en && wr_idx == IDX_CTRL) begin
        ctrl_o <= ctrl_merge(ctrl_o, wr_data);
      end
      if (wr_en && wr_idx == IDX_OEN)    oen_o    <= wr_data & GATE_MASK;
      if (wr_en && wr_idx == IDX_STOPEN) stopen_o <= wr_data & GATE_MASK;
      if (wr_en && wr_idx == IDX_COUNT)  count_o  <= wr_data;
    end
  end

  assign cap_done_o = cap_done;

  always_comb begin
    case (rd_idx)
      IDX_CTRL:   rd_data = ctrl_o;
      IDX_OEN:    rd_data = oen_o;
      IDX_STOPEN: rd_data = stopen_o;
      IDX_PINS:   rd_data = {pins_q, 3'b000};
      IDX_REVVEN: rd_data = REVVEN_VAL;
      IDX_DEVID:  rd_data = DEVID_VAL;
      IDX_COUNT:  rd_data = count_o;
      default:    rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic [7:0] rd_data,
  input  logic [7:0] count_val,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_drive
);
  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] ADDR_RD = {DEV_ADDR, 1'b1};

  link_state_e state;
  logic [3:0]  bit_cnt;
  logic [7:0]  sh, idx, wleft, rleft;
  logic        is_read, ack_given, host_ack, rx_ack, rx_state;

  assign rd_idx   = idx;
  assign rx_state = (state == ST_ADDR) || (state == ST_INDEX) ||
                    (state == ST_COUNT) || (state == ST_WDATA);

  always_comb begin
    case (state)
      ST_ADDR:  rx_ack = (sh == ADDR_WR) || (sh == ADDR_RD);
      ST_WDATA: rx_ack = (wleft != 8'd0);
      default:  rx_ack = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_cnt <= 4'd0; sh <= 8'h00; idx <= 8'h00;
      wleft <= 8'h00; rleft <= 8'h00; is_read <= 1'b0; ack_given <= 1'b0;
      host_ack <= 1'b0; wr_en <= 1'b0; wr_idx <= 8'h00; wr_data <= 8'h00;
      sda_drive <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (ev_stop) begin
        state <= ST_IDLE;
        sda_drive <= 1'b0;
      end else if (ev_start) begin
        state <= ST_ADDR;
        bit_cnt <= 4'd0;
        sda_drive <= 1'b0;
      end else if (rx_state) begin
        if (ev_rise) begin
          sh <= {sh[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (ev_fall && bit_cnt == 4'd8) begin
          case (state)
            ST_ADDR:  is_read <= (sh == ADDR_RD);
            ST_INDEX: idx <= sh;
            ST_COUNT: wleft <= sh;
            default: if (rx_ack) begin
              wr_en <= 1'b1; wr_idx <= idx; wr_data <= sh;
              idx <= idx + 8'd1; wleft <= wleft - 8'd1;
            end
          endcase
          ack_given <= rx_ack;
          sda_drive <= rx_ack;
          state <= ack_slot(state);
        end
      end else begin
        case (state)
          ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: if (ev_fall) begin
            sda_drive <= 1'b0;
            bit_cnt <= 4'd0;
            if (!ack_given) state <= ST_IDLE;
            else if (state == ST_ADDR_ACK && is_read) begin
              sh <= count_val; rleft <= count_val;
              sda_drive <= ~count_val[7];
              state <= ST_TX;
            end else if (state == ST_ADDR_ACK)  state <= ST_INDEX;
            else if (state == ST_INDEX_ACK)     state <= ST_COUNT;
            else                                state <= ST_WDATA;
          end
          ST_TX: begin
            if (ev_rise) bit_cnt <= bit_cnt + 4'd1;
            else if (ev_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_drive <= 1'b0;
                state <= ST_TX_ACK;
              end else begin
                sh <= {sh[6:0], 1'b1};
                sda_drive <= ~sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (ev_rise) host_ack <= ~sda_s;
            else if (ev_fall) begin
              bit_cnt <= 4'd0;
              if (!host_ack) state <= ST_IDLE;
              else begin
                state <= ST_TX;
                if (rleft != 8'd0) begin
                  sh <= rd_data; sda_drive <= ~rd_data[7];
                  idx <= idx + 8'd1; rleft <= rleft - 8'd1;
                end else begin
                  sh <= 8'hFF; sda_drive <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h6E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       sda_o,
  input  logic [3:0] pin_fsel,
  input  logic       pin_spread,
  output logic [7:0] cfg_ctrl_o,
  output logic [7:0] cfg_oen_o,
  output logic [7:0] cfg_stopen_o
);
  logic       sda_s, ev_start, ev_stop, ev_scl_rise, ev_scl_fall;
  logic       wr_en, cap_done, sda_drive;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, count_val;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_scl_rise), .ev_fall(ev_scl_fall)
  );

  smb_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_scl_rise), .ev_fall(ev_scl_fall), .rd_data(rd_data), .count_val(count_val),
    .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_drive(sda_drive)
  );

  smb_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .pin_fsel(pin_fsel), .pin_spread(pin_spread),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .ctrl_o(cfg_ctrl_o), .oen_o(cfg_oen_o), .stopen_o(cfg_stopen_o),
    .count_o(count_val), .cap_done_o(cap_done)
  );

  assign sda_oe = sda_drive;
  assign sda_o  = 1'b0;
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_scl_fall,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [7:0] wr_idx,
  input logic [7:0] wr_data,
  input logic [7:0] count_val,
  input logic       cap_done,
  input logic [7:0] cfg_ctrl_o
);
  assert_drive_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(ev_start) && !$past(ev_stop)) |-> $past(ev_scl_fall));

  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  assert_count_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 8'd6) |=> (count_val == $past(wr_data)));

  assert_strap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !cfg_ctrl_o[2]) |=> $stable(cfg_ctrl_o[7:3]));
endmodule

bind smb_cfg_target smb_cfg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_scl_fall(ev_scl_fall), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_data(wr_data), .count_val(count_val), .cap_done(cap_done), .cfg_ctrl_o(cfg_ctrl_o)
);

// File: tb/test_smb_cfg_target.sv
module test_smb_cfg_target;
  localparam int Q = 5;
  localparam logic [7:0] AW = 8'hDC;
  localparam logic [7:0] AR = 8'hDD;
  // {index, written byte, expected readback}
  localparam logic [23:0] VEC [0:5] = '{
    24'h01_00_00,   // R6 all enables cleared
    24'h01_FF_66,   // R6 only gated bits stored
    24'h02_0F_06,   // R6 stop-enable mask
    24'h04_55_81,   // R8 revision/vendor fixed
    24'h05_AA_08,   // R8 device id fixed
    24'h09_12_00    // R8 beyond last register
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1;
  logic [3:0] pin_fsel = 4'hA;
  logic pin_spread = 1'b1;
  logic sda_oe, sda_o, sda_bus;
  logic [7:0] cfg_ctrl_o, cfg_oen_o, cfg_stopen_o;
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  logic       wack [0:7];
  logic       addr_ack;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus = host_sda & ~(sda_oe & ~sda_o);

  smb_cfg_target i_smb_cfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe), .sda_o(sda_o),
    .pin_fsel(pin_fsel), .pin_spread(pin_spread), .cfg_ctrl_o(cfg_ctrl_o),
    .cfg_oen_o(cfg_oen_o), .cfg_stopen_o(cfg_stopen_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); host_sda = 1; scl = 1; wait_q(); host_sda = 0; wait_q(); scl = 0; wait_q(); endtask
  task automatic bus_rstart(); host_sda = 1; wait_q(); scl = 1; wait_q(); host_sda = 0; wait_q(); scl = 0; wait_q(); endtask
  task automatic bus_stop(); host_sda = 0; wait_q(); scl = 1; wait_q(); host_sda = 1; wait_q(); endtask
  task automatic put_bit(input logic b); host_sda = b; wait_q(); scl = 1; wait_q(); scl = 0; wait_q(); endtask
  task automatic get_bit(output logic b);
    host_sda = 1; wait_q(); scl = 1;
    repeat (3) @(negedge clk);
    b = sda_bus;
    repeat (Q - 3) @(negedge clk);
    scl = 0; wait_q();
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~ack);
  endtask

  // Write frame: index, count field cnt, then n data bytes from wbuf.
  task automatic wr_seq(input logic [7:0] idx, input logic [7:0] cnt, input int n);
    logic a;
    bus_start();
    send_byte(AW, addr_ack);
    send_byte(idx, a);
    send_byte(cnt, a);
    for (int i = 0; i < n; i++) send_byte(wbuf[i], wack[i]);
    bus_stop();
  endtask

  // Read frame: count byte into rbuf[0], then n more bytes; last one NACKed.
  task automatic rd_seq(input logic [7:0] idx, input int n);
    logic a;
    bus_start();
    send_byte(AW, a);
    send_byte(idx, a);
    bus_rstart();
    send_byte(AR, a);
    for (int i = 0; i <= n; i++) recv_byte(i < n, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 reset strap latch", cfg_ctrl_o, 8'hA8);
    chk("R6 reset oen", cfg_oen_o, 8'h66);
    chk("R6 reset stopen", cfg_stopen_o, 8'h00);
    chk("R10 idle release", {7'd0, sda_oe}, 8'h00);

    rd_seq(8'd3, 1);
    chk("R4 count reset", rbuf[0], 8'h07);
    chk("R7 live pins", rbuf[1], 8'hA8);

    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][15:8];
      wr_seq(VEC[v][23:16], 8'd1, 1);
      chk("R8 R6 table write ack", {7'd0, wack[0]}, 8'h01);
      rd_seq(VEC[v][23:16], 1);
      chk("R3 table count byte", rbuf[0], 8'h07);
      chk("R6 R8 table readback", rbuf[1], VEC[v][7:0]);
    end

    pin_fsel = 4'h5; pin_spread = 1'b0;
    rd_seq(8'd3, 1);
    chk("R7 pins follow", rbuf[1], 8'h50);
    chk("R5 strap held", cfg_ctrl_o, 8'hA8);

    wbuf[0] = 8'hF3; wr_seq(8'd0, 8'd1, 1);
    chk("R5 gated write", cfg_ctrl_o, 8'hAB);
    wbuf[0] = 8'h04; wr_seq(8'd0, 8'd1, 1);
    chk("R5 sw select set", cfg_ctrl_o, 8'hAC);
    wbuf[0] = 8'h73; wr_seq(8'd0, 8'd1, 1);
    chk("R5 sw override", cfg_ctrl_o, 8'h73);

    wbuf[0] = 8'h02; wbuf[1] = 8'h40; wr_seq(8'd1, 8'd2, 2);
    chk("R2 first byte", cfg_oen_o, 8'h02);
    chk("R2 auto increment", cfg_stopen_o, 8'h40);
    chk("R1 write address ack", {7'd0, addr_ack}, 8'h01);

    wbuf[0] = 8'h20; wbuf[1] = 8'h22; wr_seq(8'd1, 8'd1, 2);
    chk("R2 in-count ack", {7'd0, wack[0]}, 8'h01);
    chk("R2 surplus nack", {7'd0, wack[1]}, 8'h00);
    chk("R2 surplus dropped", cfg_stopen_o, 8'h40);

    rd_seq(8'd6, 1);
    chk("R4 count unaffected", rbuf[1], 8'h07);
    wbuf[0] = 8'h03; wr_seq(8'd6, 8'd1, 1);
    rd_seq(8'd4, 4);
    chk("R4 count programmed", rbuf[0], 8'h03);
    chk("R3 byte N", rbuf[1], 8'h81);
    chk("R3 byte N+1", rbuf[2], 8'h08);
    chk("R3 byte N+2", rbuf[3], 8'h03);
    chk("R3 past count released", rbuf[4], 8'hFF);

    bus_start();
    send_byte(8'hA0, a);
    chk("R1 foreign address nack", {7'd0, a}, 8'h00);
    send_byte(8'h01, a); send_byte(8'h01, a); send_byte(8'h00, a);
    bus_stop();
    chk("R1 foreign ignored", cfg_oen_o, 8'h20);

    bus_start();
    send_byte(AW, a); send_byte(8'h01, a); send_byte(8'h01, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk("R9 stop mid-byte", cfg_oen_o, 8'h20);

    bus_start();
    send_byte(AW, a); send_byte(8'h02, a); send_byte(8'h01, a);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_rstart();
    send_byte(AW, a); send_byte(8'h02, a); send_byte(8'h01, a); send_byte(8'h66, a);
    bus_stop();
    chk("R9 start mid-byte", cfg_stopen_o, 8'h66);
    chk("R10 released after stop", {7'd0, sda_oe}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule